// File: doc/BRIEF.md
# External Interrupt Sense Conditioner

This block sits between seven external interrupt pins and a vectored interrupt controller. Each pin is first brought into the core clock domain by a two-stage synchronizer. It is then adapted to the way it has been configured. A line can be level-sensitive or edge-triggered, and it can be active-high or active-low. Whatever the line's configuration, it reaches the controller as one plain active-high request. An edge-configured line holds its event in a sticky pending flag until software clears it. A level-configured line passes straight through.

A small word-wide register port lets software program three things: the detection type of each line, its polarity and its per-line enable. The same port reads back the pending flags and clears them by writing ones. The block also drives a single wake output that is high whenever any conditioned request is high. The power controller uses it to leave a low-power state.

Top module: `xirq_conditioner`

## Requirements
- R1: After reset every line is level-sensitive, active-high and enabled, and no flag is pending. With all inputs low, `req` and `wake` are 0.
- R2: A line in level mode with active-high polarity drives `req` to its input value with no latching. The output changes on the second rising clock edge after the input changes.
- R3: Setting a line's polarity bit (register select 1) to 1 makes it active-low. In level mode `req` is then high while the input is low.
- R4: Setting a line's mode bit (register select 0) to 1 makes it edge-triggered. With active-high polarity, a rising input edge sets a sticky request. The request appears on the third rising clock edge after the input change and stays high after the input falls.
- R5: An edge-triggered line with active-low polarity sets its sticky request on a falling input edge and ignores rising edges.
- R6: Writing to register select 3 clears each pending flag whose data bit is 1 and leaves the others unchanged. If a new active edge is detected on the same clock edge as the clear, the flag stays set.
- R7: An enable bit of 0 (register select 2) forces that line's `req` low. Its pending flag is kept and reappears when the line is enabled again.
- R8: `wake` is high exactly when at least one bit of `req` is high.
- R9: Changing a line's polarity while its input is steady does not create a pending event.
- R10: A line in level mode holds no pending flag. A flag that was pending when the line left edge mode is discarded.
- R11: `rdata` returns the selected register: 0 mode, 1 polarity, 2 enable, 3 pending flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 7 | Asynchronous external interrupt lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 7 | Write data, one bit per line |
| rdata | output | 7 | Read data for the selected register |
| req | output | 7 | Conditioned active-high requests |
| wake | output | 1 | Any request active |

## Verification
The hardest case to reach is a clear write that lands on the same clock edge as a fresh active edge. Reaching it requires the synchronizer and edge-detect delay to be counted exactly. The bench drives the new input edge, waits two rising clock edges, and then issues the clear so that the clear and the edge detection share one edge. Polarity flips on a steady input and a switch from edge mode to level mode with a flag pending are also driven on purpose. Both show that no phantom event is created and that no stale event survives.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE = 2'd0,
        SEL_POL  = 2'd1,
        SEL_EN   = 2'd2,
        SEL_PEND = 2'd3
    } xirq_sel_e;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_cfg_regs.sv
module xirq_cfg_regs
    import xirq_pkg::*;
#(
    parameter int LINES = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] addr,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] pend,
    output logic [LINES-1:0] mode,
    output logic [LINES-1:0] pol,
    output logic [LINES-1:0] en,
    output logic [LINES-1:0] clr,
    output logic [LINES-1:0] rdata
);
    typedef struct packed {
        logic [LINES-1:0] mode;
        logic [LINES-1:0] pol;
        logic [LINES-1:0] en;
    } cfg_t;

    cfg_t      cfg_d, cfg_q;
    xirq_sel_e sel;

    always_comb begin
        sel   = xirq_sel_e'(addr);
        cfg_d = cfg_q;
        clr   = '0;
        if (wr_en) begin
            case (sel)
                SEL_MODE: cfg_d.mode = wdata;
                SEL_POL:  cfg_d.pol  = wdata;
                SEL_EN:   cfg_d.en   = wdata;
                SEL_PEND: clr        = wdata;
            endcase
        end
        case (sel)
            SEL_MODE: rdata = cfg_q.mode;
            SEL_POL:  rdata = cfg_q.pol;
            SEL_EN:   rdata = cfg_q.en;
            SEL_PEND: rdata = pend;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode <= '0;
            cfg_q.pol  <= '0;
            cfg_q.en   <= '1;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode = cfg_q.mode;
    assign pol  = cfg_q.pol;
    assign en   = cfg_q.en;
endmodule

// File: rtl/xirq_lane.sv
module xirq_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic s_in,
    input  logic mode,
    input  logic pol,
    input  logic en,
    input  logic clr,
    output logic pend,
    output logic req
);
    typedef struct packed {
        logic prev;
        logic pend;
    } lane_t;

    lane_t st_d, st_q;
    logic  cur_act, prev_act, rise;

    always_comb begin
        cur_act  = s_in ^ pol;
        prev_act = st_q.prev ^ pol;
        rise     = cur_act & ~prev_act;
        st_d.prev = s_in;
        if (mode) begin
            st_d.pend = (st_q.pend & ~clr) | rise;
        end else begin
            st_d.pend = 1'b0;
        end
        req = en & (mode ? st_q.pend : cur_act);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/xirq_conditioner.sv
module xirq_conditioner
    import xirq_pkg::*;
#(
    parameter int LINES       = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] irq_raw,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] addr,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] rdata,
    output logic [LINES-1:0] req,
    output logic             wake
);
    logic [LINES-1:0] s_q;
    logic [LINES-1:0] mode_q, pol_q, en_q, clr_q, pend_q;

    xirq_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_raw),
        .dout (s_q)
    );

    xirq_cfg_regs #(.LINES(LINES)) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .addr (addr),
        .wdata(wdata),
        .pend (pend_q),
        .mode (mode_q),
        .pol  (pol_q),
        .en   (en_q),
        .clr  (clr_q),
        .rdata(rdata)
    );

    for (genvar i = 0; i < LINES; i++) begin : g_lane
        xirq_lane u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .s_in (s_q[i]),
            .mode (mode_q[i]),
            .pol  (pol_q[i]),
            .en   (en_q[i]),
            .clr  (clr_q[i]),
            .pend (pend_q[i]),
            .req  (req[i])
        );
    end

    assign wake = |req;
endmodule

// File: rtl/xirq_conditioner_chk.sv
module xirq_conditioner_chk #(
    parameter int LINES = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LINES-1:0] irq_raw,
    input logic [LINES-1:0] req,
    input logic [LINES-1:0] mode_q,
    input logic [LINES-1:0] pol_q,
    input logic [LINES-1:0] en_q,
    input logic [LINES-1:0] pend_q,
    input logic [LINES-1:0] clr_q
);
    logic [1:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_cnt <= '0;
        end else if (warm_cnt != 2'd3) begin
            warm_cnt <= warm_cnt + 2'd1;
        end
    end

    assign warm = (warm_cnt == 2'd3);

    for (genvar i = 0; i < LINES; i++) begin : g_chk
        // R2/R3: level output tracks the pin two edges back, polarity applied
        assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (warm && !mode_q[i] && en_q[i]) |-> (req[i] == ($past(irq_raw[i], 2) ^ pol_q[i])));

        // R4/R6: a pending flag in edge mode survives unless a clear hits it
        assert_pend_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && mode_q[i] && !clr_q[i]) |=> pend_q[i]);

        // R7: a disabled line never requests
        assert_disabled_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            !en_q[i] |-> !req[i]);

        // R10: level mode leaves no pending flag behind
        assert_level_nopend_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !mode_q[i] |=> !pend_q[i]);
    end
endmodule

bind xirq_conditioner xirq_conditioner_chk #(.LINES(LINES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_raw(irq_raw),
    .req    (req),
    .mode_q (mode_q),
    .pol_q  (pol_q),
    .en_q   (en_q),
    .pend_q (pend_q),
    .clr_q  (clr_q)
);

// File: tb/sim_xirq_conditioner.sv
`timescale 1ns/1ps
module sim_xirq_conditioner;
    localparam int LINES = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LINES-1:0] irq_raw = '0;
    logic             wr_en = 1'b0;
    logic [1:0]       addr = '0;
    logic [LINES-1:0] wdata = '0;
    logic [LINES-1:0] rdata;
    logic [LINES-1:0] req;
    logic             wake;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    xirq_conditioner #(.LINES(LINES)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_raw(irq_raw),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .req    (req),
        .wake   (wake)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n   = 1'b0;
        irq_raw = '0;
        wr_en   = 1'b0;
        addr    = '0;
        wdata   = '0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic wr(input logic [1:0] a, input logic [LINES-1:0] d);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [LINES-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic t_reset();
        logic [LINES-1:0] v;
        do_reset();
        check("R1 req after reset", req, 0);
        check("R1 wake after reset", wake, 0);
        rd(2'd0, v); check("R11 mode readback", v, 7'h00);
        rd(2'd1, v); check("R11 polarity readback", v, 7'h00);
        rd(2'd2, v); check("R11 enable readback", v, 7'h7F);
        rd(2'd3, v); check("R11 pending readback", v, 7'h00);
    endtask

    task automatic t_level_high();
        do_reset();
        irq_raw = 7'h01;
        step(1); check("R2 level not yet after one edge", req, 7'h00);
        step(1); check("R2 level after two edges", req, 7'h01);
        check("R8 wake with one request", wake, 1);
        irq_raw = 7'h00;
        step(2); check("R2 level no latching", req, 7'h00);
        irq_raw = 7'h5A;
        step(2); check("R2 level pattern", req, 7'h5A);
    endtask

    task automatic t_level_low();
        logic [LINES-1:0] v;
        do_reset();
        wr(2'd1, 7'h04);
        check("R3 active-low asserted on low input", req, 7'h04);
        irq_raw = 7'h04;
        step(2); check("R3 active-low released on high input", req, 7'h00);
        rd(2'd1, v); check("R11 polarity after write", v, 7'h04);
    endtask

    task automatic t_edge_rise();
        logic [LINES-1:0] v;
        do_reset();
        wr(2'd0, 7'h12);
        irq_raw = 7'h12;
        step(2); check("R4 edge not yet after two edges", req, 7'h00);
        step(1); check("R4 edge after three edges", req, 7'h12);
        irq_raw = 7'h00;
        step(4); check("R4 sticky after input falls", req, 7'h12);
        rd(2'd3, v); check("R11 pending readback", v, 7'h12);
        wr(2'd3, 7'h10); check("R6 selective clear", req, 7'h02);
        wr(2'd3, 7'h02); check("R6 second clear", req, 7'h00);
    endtask

    task automatic t_edge_fall();
        do_reset();
        wr(2'd1, 7'h20);
        check("R3 level active-low before edge mode", req, 7'h20);
        wr(2'd0, 7'h20);
        check("R5 no event on entering edge mode", req, 7'h00);
        irq_raw = 7'h20;
        step(3); check("R5 rising input ignored", req, 7'h00);
        irq_raw = 7'h00;
        step(2); check("R5 falling edge not yet", req, 7'h00);
        step(1); check("R5 falling edge latched", req, 7'h20);
    endtask

    task automatic t_pol_change();
        logic [LINES-1:0] v;
        do_reset();
        irq_raw = 7'h40;
        step(3); check("R2 level high before switch", req, 7'h40);
        wr(2'd0, 7'h40);
        check("R9 steady high gives no event", req, 7'h00);
        wr(2'd1, 7'h40);
        step(3); check("R9 polarity flip to low no event", req, 7'h00);
        wr(2'd1, 7'h00);
        step(3); check("R9 polarity flip back no event", req, 7'h00);
        rd(2'd3, v); check("R9 pending stays empty", v, 7'h00);
    endtask

    task automatic t_enable();
        logic [LINES-1:0] v;
        do_reset();
        wr(2'd0, 7'h02);
        irq_raw = 7'h02;
        step(3);
        irq_raw = 7'h00;
        check("R4 pending set on line 1", req, 7'h02);
        wr(2'd2, 7'h7D);
        check("R7 disabled line quiet", req, 7'h00);
        check("R8 wake low when all quiet", wake, 0);
        rd(2'd3, v); check("R7 pending kept while disabled", v, 7'h02);
        wr(2'd2, 7'h7F);
        check("R7 request back after enable", req, 7'h02);
    endtask

    task automatic t_discard();
        logic [LINES-1:0] v;
        do_reset();
        wr(2'd0, 7'h10);
        irq_raw = 7'h10;
        step(3);
        irq_raw = 7'h00;
        step(2); check("R4 pending on line 4", req, 7'h10);
        wr(2'd0, 7'h00);
        check("R10 level mode follows low input", req, 7'h00);
        step(1);
        wr(2'd0, 7'h10);
        check("R10 pending discarded", req, 7'h00);
        rd(2'd3, v); check("R10 pending readback empty", v, 7'h00);
    endtask

    task automatic t_collision();
        do_reset();
        wr(2'd0, 7'h01);
        irq_raw = 7'h01;
        step(3);
        irq_raw = 7'h00;
        step(3); check("R6 pending before collision", req, 7'h01);
        irq_raw = 7'h01;
        step(1);
        step(1);
        wr(2'd3, 7'h01);
        check("R6 set wins over same-edge clear", req, 7'h01);
        wr(2'd3, 7'h01);
        check("R6 plain clear afterwards", req, 7'h00);
    endtask

    task automatic t_wake();
        do_reset();
        irq_raw = 7'h48;
        step(2);
        check("R8 two level requests", req, 7'h48);
        check("R8 wake high", wake, 1);
        irq_raw = 7'h00;
        step(2);
        check("R8 wake low", wake, 0);
    endtask

    initial begin
        t_reset();
        t_level_high();
        t_level_low();
        t_edge_rise();
        t_edge_fall();
        t_pol_change();
        t_enable();
        t_discard();
        t_collision();
        t_wake();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule